// File: doc/BRIEF.md
# Receive alignment error counter

This block sits beside an Ethernet MAC receive path and tallies frames that arrive misaligned and corrupted. At each frame end the MAC presents the whole-byte length of the frame, a flag that marks a trailing partial byte, a flag for a failed frame check sequence, and a flag for a VLAN tag. A configuration input widens the accepted length range for jumbo traffic. A frame adds one to the tally only when all of these hold:

- it ends with a partial byte;
- its check sequence failed;
- its whole-byte length lies inside the legal window.

Software reads the tally through a single-cycle read strobe. The read data is registered and appears on the cycle after the strobe. The read also clears the tally, so each read reports the errors seen since the previous read. The tally stops at its all-ones value and does not wrap.

Top module: `rx_align_err_cnt`

## Requirements
- R1: A frame-end strobe adds one to the count only when both the partial-byte flag and the check-sequence-error flag are 1. A frame missing either flag leaves the count unchanged, and cycles without the strobe leave it unchanged too.
- R2: The lower length bound is 64 whole bytes and is inclusive. A qualifying frame of length 63 is not counted, and a frame of length 64 is counted.
- R3: With jumbo mode off, the upper bound is 1518 bytes for untagged frames (tagged flag 0) and 1522 bytes for tagged frames (tagged flag 1). Frames above the active bound are not counted.
- R4: With the jumbo input at 1, the upper bound is 2048 bytes for both tagged and untagged frames. A frame of 2049 bytes is not counted.
- R5: A frame whose whole-byte length equals the active upper bound, with the partial-byte flag set and a bad check sequence, is counted.
- R6: The count is 32 bits wide by default. It holds at its all-ones value instead of wrapping.
- R7: A read strobe loads the current count into the read data register, where it is visible on the next cycle, and resets the count to zero. The read data holds its value until the next read strobe.
- R8: After reset, both the count and the read data are zero.
- R9: If a qualifying frame arrives in the same cycle as a read strobe, the read returns the count from before that frame, and the count afterwards is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frm_end_i | input | 1 | One-cycle strobe marking the end of a received frame |
| frm_len_i | input | LEN_W (12) | Frame length in whole bytes |
| frm_partial_i | input | 1 | Frame ends with an extra partial byte |
| frm_fcs_bad_i | input | 1 | Frame check sequence failed |
| frm_tagged_i | input | 1 | Frame carries a VLAN tag |
| jumbo_en_i | input | 1 | Raises the upper length bound to the jumbo limit |
| rd_en_i | input | 1 | Single-cycle read strobe; clears the count |
| rd_data_o | output | CNT_W (32) | Registered read data, valid the cycle after rd_en_i |

## Verification
The checker watches several properties on every clock:

- a counted event always has both error flags and a length inside the widest legal window;
- an idle cycle leaves the count alone;
- a full count stays full;
- a read moves the pre-read count onto the read data and leaves zero or one behind.

Only the bench scenarios can show that the tagged, untagged and jumbo bounds each sit at exactly the right byte. The same holds for the read value after a series of mixed frames. Saturation is shown on a narrow counter instance, because the full width cannot be filled in a short run.

// File: rtl/rx_align_pkg.sv
package rx_align_pkg;
  typedef enum logic [1:0] {
    LIM_STD   = 2'd0,
    LIM_TAG   = 2'd1,
    LIM_JUMBO = 2'd2
  } lim_sel_e;

  localparam int unsigned DEF_MIN_LEN   = 64;
  localparam int unsigned DEF_STD_MAX   = 1518;
  localparam int unsigned DEF_TAG_MAX   = 1522;
  localparam int unsigned DEF_JUMBO_MAX = 2048;
endpackage

// File: rtl/rx_align_limit.sv
module rx_align_limit
  import rx_align_pkg::*;
#(
  parameter int unsigned LEN_W     = 12,
  parameter int unsigned STD_MAX   = DEF_STD_MAX,
  parameter int unsigned TAG_MAX   = DEF_TAG_MAX,
  parameter int unsigned JUMBO_MAX = DEF_JUMBO_MAX
) (
  input  logic             tagged_i,
  input  logic             jumbo_i,
  output logic [LEN_W-1:0] max_len_o
);
  lim_sel_e sel;

  always_comb begin
    if (jumbo_i)       sel = LIM_JUMBO;
    else if (tagged_i) sel = LIM_TAG;
    else               sel = LIM_STD;
  end

  always_comb begin
    unique case (sel)
      LIM_TAG:   max_len_o = LEN_W'(TAG_MAX);
      LIM_JUMBO: max_len_o = LEN_W'(JUMBO_MAX);
      default:   max_len_o = LEN_W'(STD_MAX);
    endcase
  end
endmodule

// File: rtl/rx_align_qualify.sv
module rx_align_qualify #(
  parameter int unsigned LEN_W   = 12,
  parameter int unsigned MIN_LEN = 64
) (
  input  logic             end_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             partial_i,
  input  logic             fcs_bad_i,
  input  logic [LEN_W-1:0] max_len_i,
  output logic             hit_o
);
  localparam logic [LEN_W-1:0] MinL = LEN_W'(MIN_LEN);

  logic in_win;

  // whole-byte length decides the window; partial byte never pushes it over
  assign in_win = (len_i >= MinL) && (len_i <= max_len_i);
  assign hit_o  = end_i && partial_i && fcs_bad_i && in_win;
endmodule

// File: rtl/rx_align_sat_cnt.sv
module rx_align_sat_cnt #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             rd_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] rd_data_o
);
  localparam logic [CNT_W-1:0] CntMax = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rd_q  <= '0;
    end else if (rd_i) begin
      rd_q  <= cnt_q;
      // event in the read cycle survives as the first count of the new window
      cnt_q <= inc_i ? CNT_W'(1) : '0;
    end else if (inc_i && (cnt_q != CntMax)) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o     = cnt_q;
  assign rd_data_o = rd_q;
endmodule

// File: rtl/rx_align_err_cnt.sv
module rx_align_err_cnt
  import rx_align_pkg::*;
#(
  parameter int unsigned LEN_W     = 12,
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned MIN_LEN   = DEF_MIN_LEN,
  parameter int unsigned STD_MAX   = DEF_STD_MAX,
  parameter int unsigned TAG_MAX   = DEF_TAG_MAX,
  parameter int unsigned JUMBO_MAX = DEF_JUMBO_MAX
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frm_end_i,
  input  logic [LEN_W-1:0] frm_len_i,
  input  logic             frm_partial_i,
  input  logic             frm_fcs_bad_i,
  input  logic             frm_tagged_i,
  input  logic             jumbo_en_i,
  input  logic             rd_en_i,
  output logic [CNT_W-1:0] rd_data_o
);
  logic [LEN_W-1:0] max_len_w;
  logic             hit_w;
  logic [CNT_W-1:0] cnt_w;

  rx_align_limit #(
    .LEN_W    (LEN_W),
    .STD_MAX  (STD_MAX),
    .TAG_MAX  (TAG_MAX),
    .JUMBO_MAX(JUMBO_MAX)
  ) u_limit (
    .tagged_i (frm_tagged_i),
    .jumbo_i  (jumbo_en_i),
    .max_len_o(max_len_w)
  );

  rx_align_qualify #(
    .LEN_W  (LEN_W),
    .MIN_LEN(MIN_LEN)
  ) u_qual (
    .end_i    (frm_end_i),
    .len_i    (frm_len_i),
    .partial_i(frm_partial_i),
    .fcs_bad_i(frm_fcs_bad_i),
    .max_len_i(max_len_w),
    .hit_o    (hit_w)
  );

  rx_align_sat_cnt #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_i    (hit_w),
    .rd_i     (rd_en_i),
    .cnt_o    (cnt_w),
    .rd_data_o(rd_data_o)
  );
endmodule

// File: rtl/rx_align_err_cnt_chk.sv
module rx_align_err_cnt_chk #(
  parameter int unsigned LEN_W     = 12,
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned MIN_LEN   = 64,
  parameter int unsigned JUMBO_MAX = 2048
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             frm_end_i,
  input logic [LEN_W-1:0] frm_len_i,
  input logic             frm_partial_i,
  input logic             frm_fcs_bad_i,
  input logic             rd_en_i,
  input logic             hit_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] rd_data_i
);
  localparam logic [CNT_W-1:0] CntMax = '1;

  a_r1_hit_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |-> (frm_end_i && frm_partial_i && frm_fcs_bad_i));

  a_r1_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frm_end_i && !rd_en_i) |=> $stable(cnt_i));

  a_r2_len_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |-> (frm_len_i >= LEN_W'(MIN_LEN)));

  a_r4_len_ceiling: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |-> (frm_len_i <= LEN_W'(JUMBO_MAX)));

  a_r6_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == CntMax && !rd_en_i) |=> (cnt_i == CntMax));

  a_r7_rd_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> (rd_data_i == $past(cnt_i)));

  a_r7_rd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_i));

  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !hit_i) |=> (cnt_i == '0));

  a_r9_rd_collide: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && hit_i) |=> (cnt_i == CNT_W'(1)));
endmodule

bind rx_align_err_cnt rx_align_err_cnt_chk #(
  .LEN_W    (LEN_W),
  .CNT_W    (CNT_W),
  .MIN_LEN  (MIN_LEN),
  .JUMBO_MAX(JUMBO_MAX)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frm_end_i    (frm_end_i),
  .frm_len_i    (frm_len_i),
  .frm_partial_i(frm_partial_i),
  .frm_fcs_bad_i(frm_fcs_bad_i),
  .rd_en_i      (rd_en_i),
  .hit_i        (hit_w),
  .cnt_i        (cnt_w),
  .rd_data_i    (rd_data_o)
);

// File: tb/rx_align_err_cnt_tb.sv
module rx_align_err_cnt_tb;
  localparam int LEN_W = 12;
  localparam int CNT_W = 32;
  localparam int SAT_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             frm_end = 1'b0;
  logic [LEN_W-1:0] frm_len = '0;
  logic             frm_partial = 1'b0;
  logic             frm_fcs_bad = 1'b0;
  logic             frm_tagged = 1'b0;
  logic             jumbo_en = 1'b0;
  logic             rd_en = 1'b0;
  logic [CNT_W-1:0] rd_data;
  logic [SAT_W-1:0] rd_data_sat;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rx_align_err_cnt #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .frm_end_i(frm_end), .frm_len_i(frm_len),
    .frm_partial_i(frm_partial), .frm_fcs_bad_i(frm_fcs_bad),
    .frm_tagged_i(frm_tagged), .jumbo_en_i(jumbo_en), .rd_en_i(rd_en),
    .rd_data_o(rd_data)
  );

  // narrow instance so saturation is reachable
  rx_align_err_cnt #(.LEN_W(LEN_W), .CNT_W(SAT_W)) u_dut_sat (
    .clk_i(clk), .rst_ni(rst_n), .frm_end_i(frm_end), .frm_len_i(frm_len),
    .frm_partial_i(frm_partial), .frm_fcs_bad_i(frm_fcs_bad),
    .frm_tagged_i(frm_tagged), .jumbo_en_i(jumbo_en), .rd_en_i(rd_en),
    .rd_data_o(rd_data_sat)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic frame(input int len, input bit part, input bit fcs, input bit tag, input bit jum);
    @(negedge clk);
    frm_end = 1'b1; frm_len = LEN_W'(len); frm_partial = part;
    frm_fcs_bad = fcs; frm_tagged = tag; jumbo_en = jum;
    @(negedge clk);
    frm_end = 1'b0; frm_partial = 1'b0; frm_fcs_bad = 1'b0;
  endtask

  task automatic read(output logic [31:0] v);
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R8 rd_data after reset", rd_data, 0);
    read(v);
    chk("R8 count after reset", v, 0);
  endtask

  task automatic t_flags();
    logic [31:0] v;
    frame(200, 1, 0, 0, 0);
    frame(200, 0, 1, 0, 0);
    frame(200, 0, 0, 0, 0);
    @(negedge clk); frm_partial = 1'b1; frm_fcs_bad = 1'b1; frm_len = 12'd200;
    @(negedge clk); frm_partial = 1'b0; frm_fcs_bad = 1'b0;
    read(v);
    chk("R1 missing flag or strobe ignored", v, 0);
    frame(200, 1, 1, 0, 0);
    read(v);
    chk("R1 both flags counted", v, 1);
  endtask

  task automatic t_lower();
    logic [31:0] v;
    frame(63, 1, 1, 0, 0);
    read(v);
    chk("R2 length 63 ignored", v, 0);
    frame(64, 1, 1, 0, 0);
    read(v);
    chk("R2 length 64 counted", v, 1);
  endtask

  task automatic t_upper();
    logic [31:0] v;
    frame(1518, 1, 1, 0, 0);
    read(v);
    chk("R5 untagged at 1518 counted", v, 1);
    frame(1519, 1, 1, 0, 0);
    read(v);
    chk("R3 untagged 1519 ignored", v, 0);
    frame(1522, 1, 1, 1, 0);
    read(v);
    chk("R5 tagged at 1522 counted", v, 1);
    frame(1523, 1, 1, 1, 0);
    frame(1522, 1, 1, 0, 0);
    read(v);
    chk("R3 tagged 1523 and untagged 1522 ignored", v, 0);
  endtask

  task automatic t_jumbo();
    logic [31:0] v;
    frame(2048, 1, 1, 0, 1);
    frame(2048, 1, 1, 1, 1);
    frame(1600, 1, 1, 0, 1);
    read(v);
    chk("R4 jumbo window counted", v, 3);
    frame(2049, 1, 1, 0, 1);
    frame(2049, 1, 1, 1, 1);
    read(v);
    chk("R4 jumbo 2049 ignored", v, 0);
  endtask

  task automatic t_read();
    logic [31:0] v;
    repeat (5) frame(100, 1, 1, 0, 0);
    read(v);
    chk("R7 read value", v, 5);
    repeat (4) @(negedge clk);
    chk("R7 read data holds", rd_data, 5);
    read(v);
    chk("R7 count cleared by read", v, 0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    repeat (3) frame(300, 1, 1, 0, 0);
    @(negedge clk);
    rd_en = 1'b1; frm_end = 1'b1; frm_len = 12'd300; frm_partial = 1'b1;
    frm_fcs_bad = 1'b1; frm_tagged = 1'b0; jumbo_en = 1'b0;
    @(negedge clk);
    rd_en = 1'b0; frm_end = 1'b0; frm_partial = 1'b0; frm_fcs_bad = 1'b0;
    chk("R9 read returns pre-event count", rd_data, 3);
    read(v);
    chk("R9 event kept after read", v, 1);
  endtask

  task automatic t_sat();
    logic [31:0] v;
    read(v);
    repeat (20) frame(500, 1, 1, 0, 0);
    read(v);
    chk("R6 wide counter value", v, 20);
    chk("R6 narrow counter saturates", 32'(rd_data_sat), 15);
    read(v);
    chk("R6 narrow counter cleared", 32'(rd_data_sat), 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_flags();
    t_lower();
    t_upper();
    t_jumbo();
    t_read();
    t_collide();
    t_sat();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule